// File: doc/BRIEF.md
# Keyclick Tone Burst Generator

This block produces a short square-wave burst that gives audible feedback when a key is pressed. A single control word written by the host carries a tone-pitch code, a length code, a loudness code and an enable flag. A write with the enable flag set immediately launches a burst of the selected pitch and length on a signed digital level output, which the audio output path sums in. When the final period has been played, the hardware clears the enable flag, and the host sees this on the read-back port.

All timing comes from one fixed reference clock. A prescaler turns it into a base tick at twice the highest tone frequency, and a half-period counter measures tone half-cycles in those ticks. The generator depends on no other converter, so it runs while the rest of the audio path is powered down.

Top module: `keyclick_gen`

## Requirements
- R1: After reset, `rd_data` reads 0 and `tone_out` is 0.
- R2: A write stores pitch code bits [2:0], length code bits [7:4], loudness code bits [10:8] and the enable flag at bit 15. `rd_data` returns these fields at the same positions, and all other bits read 0.
- R3: A write with bit 15 set starts a burst. In the first cycle after the write, `tone_out` is positive.
- R4: Each half-cycle lasts TICK_DIV × 2^(7−p) clock cycles, where p is the pitch code (62.5 Hz × 2^p at a 16 kHz base tick). The level holds steady within a half-cycle and changes sign at its end.
- R5: A burst lasts 2 × (d + 1) full periods, where d is the length code, so 4 × (d + 1) half-cycles.
- R6: On the final clock of the burst, the enable flag clears by itself and `tone_out` returns to 0 in the next cycle.
- R7: During a burst, `tone_out` is +(a + 1) or −(a + 1), where a is the loudness code.
- R8: While no burst is running, `tone_out` is 0.
- R9: A write with bit 15 set during a burst restarts the burst from its first half-cycle with the new fields. This holds even when the write falls on the burst's final clock.
- R10: A write with bit 15 clear stores the fields and stops any running burst, so `tone_out` is 0 in the next cycle.
- R11: Every burst begins with a positive half-cycle and ends after a negative half-cycle, so it always completes a whole period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Control-word write strobe, one cycle |
| wr_data | input | 16 | Control word to write |
| rd_data | output | 16 | Control word read-back, with the live enable flag |
| tone_out | output | AMP_W+2 | Signed square-wave level, 0 when idle |

## Verification
Two functions can fall in the same cycle: a host write and the self-clearing of the enable flag at the end of a burst. The bench starts a short burst and counts the exact number of cycles to its end. It then times a second write so that the write is captured on the same clock edge as the burst's final half-cycle boundary. The reference model gives the write priority, so the bench expects the enable flag to stay set and a fresh positive half-cycle with the new loudness. A dropped restart or a lingering clear both show up as a mismatch on that cycle.

// File: rtl/keyclick_pkg.sv
package keyclick_pkg;
  localparam int FREQ_LSB = 0;
  localparam int DUR_LSB  = 4;
  localparam int AMP_LSB  = 8;
  localparam int EN_BIT   = 15;

  // Base ticks per half-cycle: the top pitch code gives one tick.
  function automatic int half_ticks(int freq_code, int freq_w);
    return 1 << (((1 << freq_w) - 1) - freq_code);
  endfunction

  // Half-cycles per burst: two full periods per length step.
  function automatic int burst_halves(int dur_code);
    return 4 * (dur_code + 1);
  endfunction

  // Output magnitude for a loudness code.
  function automatic int level_mag(int amp_code);
    return amp_code + 1;
  endfunction
endpackage

// File: rtl/kc_tick_div.sv
module kc_tick_div #(
  parameter int DIV = 750
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic tick
);
  localparam int CNT_W = $clog2(DIV + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(DIV - 1));
  assign tick = run && wrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (restart || !run) cnt_q <= '0;
    else if (wrap)           cnt_q <= '0;
    else                     cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/kc_burst_seq.sv
module kc_burst_seq
  import keyclick_pkg::*;
#(
  parameter int FREQ_W   = 3,
  parameter int DUR_W    = 4,
  parameter int AMP_W    = 3,
  parameter int HALF_W   = 8,
  parameter int HALVES_W = 7,
  parameter int TONE_W   = 5
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     stop,
  input  logic                     tick,
  input  logic [FREQ_W-1:0]        freq_in,
  input  logic [DUR_W-1:0]         dur_in,
  input  logic [AMP_W-1:0]         amp_in,
  output logic                     active,
  output logic signed [TONE_W-1:0] tone,
  output logic                     half_end,
  output logic                     burst_end
);
  logic                     active_q;
  logic                     phase_hi_q;
  logic [HALF_W-1:0]        tick_cnt_q;
  logic [HALF_W-1:0]        half_lim_q;
  logic [HALVES_W-1:0]      half_cnt_q;
  logic [HALVES_W-1:0]      halves_lim_q;
  logic signed [TONE_W-1:0] mag_q;

  assign active    = active_q;
  assign half_end  = active_q && tick && (tick_cnt_q == half_lim_q - 1'b1);
  assign burst_end = half_end && (half_cnt_q == halves_lim_q - 1'b1);

  always_comb begin
    if (!active_q)       tone = '0;
    else if (phase_hi_q) tone = mag_q;
    else                 tone = -mag_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q     <= 1'b0;
      phase_hi_q   <= 1'b0;
      tick_cnt_q   <= '0;
      half_cnt_q   <= '0;
      half_lim_q   <= '0;
      halves_lim_q <= '0;
      mag_q        <= '0;
    end else if (start) begin
      active_q     <= 1'b1;
      phase_hi_q   <= 1'b1;
      tick_cnt_q   <= '0;
      half_cnt_q   <= '0;
      half_lim_q   <= HALF_W'(half_ticks(int'(freq_in), FREQ_W));
      halves_lim_q <= HALVES_W'(burst_halves(int'(dur_in)));
      mag_q        <= TONE_W'(level_mag(int'(amp_in)));
    end else if (stop || burst_end) begin
      active_q   <= 1'b0;
      phase_hi_q <= 1'b0;
    end else if (half_end) begin
      phase_hi_q <= !phase_hi_q;
      tick_cnt_q <= '0;
      half_cnt_q <= half_cnt_q + 1'b1;
    end else if (tick) begin
      tick_cnt_q <= tick_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/keyclick_gen.sv
module keyclick_gen
  import keyclick_pkg::*;
#(
  parameter int TICK_DIV = 750,
  parameter int FREQ_W   = 3,
  parameter int DUR_W    = 4,
  parameter int AMP_W    = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [15:0]             wr_data,
  output logic [15:0]             rd_data,
  output logic signed [AMP_W+1:0] tone_out
);
  localparam int TONE_W   = AMP_W + 2;
  localparam int HALF_W   = ((1 << FREQ_W) - 1) + 1;
  localparam int HALVES_W = $clog2(4 * (1 << DUR_W) + 1);

  logic [FREQ_W-1:0] freq_q;
  logic [DUR_W-1:0]  dur_q;
  logic [AMP_W-1:0]  amp_q;
  logic              en_q;

  logic start, stop, tick, half_end, burst_end, seq_active;
  logic unused_bits;

  assign start       = wr_en && wr_data[EN_BIT];
  assign stop        = wr_en && !wr_data[EN_BIT];
  assign unused_bits = ^{wr_data[14:11], wr_data[7], wr_data[3], seq_active};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      freq_q <= '0;
      dur_q  <= '0;
      amp_q  <= '0;
      en_q   <= 1'b0;
    end else if (wr_en) begin
      freq_q <= wr_data[FREQ_LSB +: FREQ_W];
      dur_q  <= wr_data[DUR_LSB +: DUR_W];
      amp_q  <= wr_data[AMP_LSB +: AMP_W];
      en_q   <= wr_data[EN_BIT];
    end else if (burst_end) begin
      en_q   <= 1'b0;
    end
  end

  always_comb begin
    rd_data                       = '0;
    rd_data[FREQ_LSB +: FREQ_W]   = freq_q;
    rd_data[DUR_LSB +: DUR_W]     = dur_q;
    rd_data[AMP_LSB +: AMP_W]     = amp_q;
    rd_data[EN_BIT]               = en_q;
  end

  kc_tick_div #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (start),
    .run     (seq_active),
    .tick    (tick)
  );

  kc_burst_seq #(
    .FREQ_W   (FREQ_W),
    .DUR_W    (DUR_W),
    .AMP_W    (AMP_W),
    .HALF_W   (HALF_W),
    .HALVES_W (HALVES_W),
    .TONE_W   (TONE_W)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .stop      (stop),
    .tick      (tick),
    .freq_in   (wr_data[FREQ_LSB +: FREQ_W]),
    .dur_in    (wr_data[DUR_LSB +: DUR_W]),
    .amp_in    (wr_data[AMP_LSB +: AMP_W]),
    .active    (seq_active),
    .tone      (tone_out),
    .half_end  (half_end),
    .burst_end (burst_end)
  );
endmodule

// File: rtl/keyclick_checker.sv
module keyclick_checker #(
  parameter int AMP_W = 3
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    wr_en,
  input logic [15:0]             wr_data,
  input logic [15:0]             rd_data,
  input logic signed [AMP_W+1:0] tone_out,
  input logic                    half_end,
  input logic                    burst_end
);
  localparam int TONE_W = AMP_W + 2;

  logic signed [TONE_W-1:0] mag;
  logic                     busy;

  assign busy = rd_data[15];
  assign mag  = $signed({2'b00, rd_data[8 +: AMP_W]}) + TONE_W'(1);

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> tone_out == '0);

  assert_start_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15]) |=> (tone_out > 0 && busy));

  assert_self_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (burst_end && !wr_en) |=> (!busy && tone_out == '0));

  assert_full_period_R11: assert property (@(posedge clk) disable iff (!rst_n)
    burst_end |-> tone_out < 0);

  assert_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (tone_out == mag || tone_out == -mag));

  assert_flip_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (half_end && !burst_end && !wr_en) |=> tone_out == -$past(tone_out));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !half_end && !wr_en) |=> $stable(tone_out));

  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[15]) |=> tone_out == '0);
endmodule

bind keyclick_gen keyclick_checker #(.AMP_W(AMP_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_data   (wr_data),
  .rd_data   (rd_data),
  .tone_out  (tone_out),
  .half_end  (half_end),
  .burst_end (burst_end)
);

// File: tb/keyclick_gen_bench.sv
module keyclick_gen_bench;
  localparam int TDIV = 3;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              wr_en = 1'b0;
  logic [15:0]       wr_data = '0;
  logic [15:0]       rd_data;
  logic signed [4:0] tone_out;

  int checks = 0;
  int errors = 0;
  string cur_req = "R1";

  // reference model state
  int m_fld = 0;   // stored fields without enable
  int m_en = 0;
  int m_act = 0;
  int m_t = 0;
  int m_h = 1;
  int m_n = 4;
  int m_a = 1;

  always #2.5 clk = ~clk;

  keyclick_gen #(.TICK_DIV(TDIV)) u_keyclick_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .tone_out(tone_out)
  );

  function automatic int cyc_half(int f);
    return TDIV * (128 >> f);
  endfunction

  function automatic logic [15:0] word(int en, int amp, int dur, int f);
    return 16'((en << 15) | (amp << 8) | (dur << 4) | f);
  endfunction

  function automatic int model_tone();
    if (m_act == 0) return 0;
    return ((m_t / m_h) % 2 == 0) ? m_a : -m_a;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_fld = 0; m_en = 0; m_act = 0; m_t = 0;
    end else if (wr_en) begin
      m_fld = int'(wr_data & 16'h07F7);
      m_en  = int'(wr_data[15]);
      m_act = m_en;
      m_t   = 0;
      m_h   = cyc_half(int'(wr_data[2:0]));
      m_n   = 4 * (int'(wr_data[7:4]) + 1);
      m_a   = int'(wr_data[10:8]) + 1;
    end else if (m_act != 0) begin
      m_t = m_t + 1;
      if (m_t == m_n * m_h) begin
        m_act = 0;
        m_en  = 0;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      check(int'(tone_out) == model_tone(), {cur_req, " tone"}, int'(tone_out), model_tone());
      check(int'(rd_data) == (m_fld | (m_en << 15)), {cur_req, " readback"},
            int'(rd_data), m_fld | (m_en << 15));
    end
  end

  task automatic write(input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1;
    wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    wr_data = '0;
  endtask

  // Measures a burst that was just launched; called at the first burst negedge.
  task automatic measure(input int f, input int dur, input int amp, input string tag);
    int n = 0;
    int first_hi = 0;
    bit in_first = 1'b1;
    int last = 0;
    check(int'(tone_out) == amp + 1, {tag, " R3 R7 first level"}, int'(tone_out), amp + 1);
    while (rd_data[15]) begin
      n++;
      if (in_first && tone_out > 0) first_hi++;
      else in_first = 1'b0;
      last = int'(tone_out);
      @(negedge clk);
    end
    check(first_hi == cyc_half(f), {tag, " R4 half length"}, first_hi, cyc_half(f));
    check(n == 4 * (dur + 1) * cyc_half(f), {tag, " R5 burst length"}, n, 4 * (dur + 1) * cyc_half(f));
    check(last == -(amp + 1), {tag, " R11 last half negative"}, last, -(amp + 1));
    check(tone_out == 0, {tag, " R6 R8 idle after end"}, int'(tone_out), 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rd_data == 16'h0, "R1 reset readback", int'(rd_data), 0);
    check(tone_out == 0, "R1 reset tone", int'(tone_out), 0);
    rst_n = 1'b1;

    cur_req = "R2";
    write(16'h7FFF & word(0, 3, 2, 5) | 16'h7808);
    check(rd_data == word(0, 3, 2, 5), "R2 fields readback", int'(rd_data), int'(word(0, 3, 2, 5)));
    check(tone_out == 0, "R10 no burst without enable", int'(tone_out), 0);

    cur_req = "R4";
    write(word(1, 0, 0, 7));
    measure(7, 0, 0, "fast");

    cur_req = "R7";
    write(word(1, 5, 1, 5));
    measure(5, 1, 5, "mid");

    cur_req = "R5";
    write(word(1, 7, 15, 0));
    measure(0, 15, 7, "slow");

    cur_req = "R9";
    write(word(1, 2, 3, 6));
    repeat (10) @(negedge clk);
    write(word(1, 4, 1, 7));
    measure(7, 1, 4, "restart");

    cur_req = "R10";
    write(word(1, 6, 2, 4));
    repeat (7) @(negedge clk);
    write(word(0, 6, 2, 4));
    check(tone_out == 0, "R10 abort tone", int'(tone_out), 0);
    check(rd_data[15] == 1'b0, "R10 abort flag", int'(rd_data[15]), 0);

    cur_req = "R9";
    write(word(1, 0, 0, 7));
    repeat (10) @(negedge clk);
    write(word(1, 3, 0, 7));
    check(rd_data[15] == 1'b1, "R9 write on final clock keeps flag", int'(rd_data[15]), 1);
    measure(7, 0, 3, "collide");

    cur_req = "R8";
    repeat (20) @(negedge clk);
    check(tone_out == 0, "R8 idle quiet", int'(tone_out), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule